// File: doc/BRIEF.md
# Dual Rolling Shutter Row Controller

This block produces the row-level control pulses for a pixel array that captures two exposures in one frame. Two row pointers move through the array at the same pace, one row per slot. The readout pointer selects its row and issues three samples to the column converters in this order: the short-exposure charge already held on the floating node, then the reset level, then the freshly integrated long-exposure charge. The shutter pointer runs a programmable number of rows ahead. On its row it resets the floating node and then transfers the short-exposure charge onto it.

The row gap sets both exposures. With a gap of G rows and a slot time T, the long exposure lasts G·T and the short exposure lasts (ROWS−G)·T. The largest gap, ROWS−1, therefore gives the shortest short exposure, one slot, and the longest long exposure, ROWS−1 slots. The block reads the gap input only when the first frame starts and at each frame wrap, so a new value changes nothing until the next frame begins.

Rows are given as two binary addresses with one strobe per pulse. A row decoder outside the block fans these out to the array. Every strobe is one clock wide and is registered. All outputs come from the same register stage, so a strobe and its row address always change together.

Top module: `dual_roll_ctrl`

## Requirements
- R1: While reset is held, every strobe and the select output are low, and both row addresses read 0.
- R2: Inside every slot of SLOT_CYCLES clocks, counted from cycle 0 of the slot, the readout strobes fire on their own cycles. The short sample comes on cycle 1, the readout reset on cycle 3, the reset sample on cycle 5, the readout transfer on cycle 7 and the long sample on cycle 9. The select output stays high during each of these strobes.
- R3: The shutter reset fires on cycle 11 of the slot and the shutter transfer on cycle 13, both addressed to the shutter row.
- R4: The readout row address steps by one at each slot end, wraps from ROWS−1 to 0, and never reaches ROWS.
- R5: During a frame, the shutter row equals (readout row + gap) modulo ROWS.
- R6: The gap input is sampled when operation first starts and at the wrap from row ROWS−1 to row 0. A change at any other time has no effect until the next frame.
- R7: A gap value of ROWS or more is treated as ROWS−1. This gives a one-slot short exposure and a long exposure of ROWS−1 slots.
- R8: With a stored gap of 0, both pointers sit on the same row, and the readout unit wins: no shutter strobe is issued in that frame.
- R9: At most one strobe is active in any cycle. A shutter strobe is never addressed to the current readout row.
- R10: While the enable input is low, the timing freezes. No strobe fires, select is low and both row addresses hold. Once enable returns, the sequence continues from the cycle where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low freezes the slot timing |
| gap_i | input | ROW_W | Row gap between the shutter and readout pointers |
| rd_row_o | output | ROW_W | Readout row address |
| sh_row_o | output | ROW_W | Shutter row address |
| rd_sel_o | output | 1 | Row select for the readout row |
| rd_rst_o | output | 1 | Floating-node reset pulse on the readout row |
| rd_tx_o | output | 1 | Charge transfer pulse on the readout row |
| sh_rst_o | output | 1 | Floating-node reset pulse on the shutter row |
| sh_tx_o | output | 1 | Charge transfer pulse on the shutter row |
| smp_s_o | output | 1 | Column strobe: stored short-exposure level |
| smp_r_o | output | 1 | Column strobe: reset level |
| smp_l_o | output | 1 | Column strobe: long-exposure level |

## Verification
The assertions assume that en_i and gap_i are always driven to known values. The row-relation check compares the shutter address against the gap stored for the current frame, not against the live input, so it depends on the gap being latched only at frame boundaries. The stimulus changes gap_i only in the middle of a frame, which makes sure a latch made too early would show up. It drops enable only partway through a slot, which checks that the timing resumes without losing a strobe. The gap values used are an ordinary gap, zero, an out-of-range value and one.

// File: rtl/drs_pkg.sv
package drs_pkg;
  // Strobe kinds; the numeric value is the bit index in the strobe vector
  typedef enum logic [2:0] {
    K_SIG_S  = 3'd0,
    K_RD_RST = 3'd1,
    K_SIG_R  = 3'd2,
    K_RD_TX  = 3'd3,
    K_SIG_L  = 3'd4,
    K_SH_RST = 3'd5,
    K_SH_TX  = 3'd6
  } strobe_e;

  localparam int unsigned NUM_STROBES   = 7;
  // strobes at or above this index belong to the shutter unit
  localparam int unsigned SHUTTER_FIRST = 5;
  // slot cycle of each strobe, indexed by strobe_e
  localparam int unsigned PHASE [NUM_STROBES] = '{1, 3, 5, 7, 9, 11, 13};
  localparam int unsigned MIN_SLOT      = 14;
endpackage

// File: rtl/drs_slot_timer.sv
module drs_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 16,
  localparam int unsigned CYC_W = $clog2(SLOT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CYC_W-1:0] cyc,
  output logic             slot_end
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(SLOT_CYCLES - 1);

  assign slot_end = run && (cyc == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (slot_end) cyc <= '0;
    else if (run)      cyc <= cyc + 1'b1;
  end
endmodule

// File: rtl/drs_row_ptr.sv
module drs_row_ptr #(
  parameter int unsigned ROWS = 240,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [ROW_W-1:0] load_val,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (load) row <= load_val;
    else if (step) row <= (row == TOP) ? '0 : row + 1'b1;
  end
endmodule

// File: rtl/drs_phase_gen.sv
module drs_phase_gen
  import drs_pkg::*;
#(
  parameter int unsigned ROWS        = 240,
  parameter int unsigned SLOT_CYCLES = 16,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned CYC_W = $clog2(SLOT_CYCLES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   sh_enable,
  input  logic [CYC_W-1:0]       cyc,
  input  logic [ROW_W-1:0]       rd_row,
  input  logic [ROW_W-1:0]       sh_row,
  output logic [NUM_STROBES-1:0] strobe_q,
  output logic                   sel_q,
  output logic [ROW_W-1:0]       rd_row_q,
  output logic [ROW_W-1:0]       sh_row_q
);
  logic [NUM_STROBES-1:0] hit;

  for (genvar k = 0; k < NUM_STROBES; k++) begin : g_phase
    if (k < SHUTTER_FIRST) begin : g_rd
      assign hit[k] = run && (cyc == CYC_W'(PHASE[k]));
    end else begin : g_sh
      // readout owns the row when both pointers coincide
      assign hit[k] = run && sh_enable && (cyc == CYC_W'(PHASE[k]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      sel_q    <= 1'b0;
      rd_row_q <= '0;
      sh_row_q <= '0;
    end else begin
      strobe_q <= hit;
      sel_q    <= run;
      rd_row_q <= rd_row;
      sh_row_q <= sh_row;
    end
  end
endmodule

// File: rtl/dual_roll_ctrl.sv
module dual_roll_ctrl
  import drs_pkg::*;
#(
  parameter int unsigned ROWS        = 240,
  parameter int unsigned SLOT_CYCLES = 16,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned CYC_W = $clog2(SLOT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ROW_W-1:0] gap_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [ROW_W-1:0] sh_row_o,
  output logic             rd_sel_o,
  output logic             rd_rst_o,
  output logic             rd_tx_o,
  output logic             sh_rst_o,
  output logic             sh_tx_o,
  output logic             smp_s_o,
  output logic             smp_r_o,
  output logic             smp_l_o
);
  initial begin
    if (SLOT_CYCLES < MIN_SLOT) $error("SLOT_CYCLES too small for the strobe phases");
  end

  logic                   started;
  logic                   start;
  logic                   run;
  logic [ROW_W-1:0]       gap_q;
  logic [ROW_W-1:0]       gap_clamped;
  logic [CYC_W-1:0]       cyc;
  logic                   slot_end;
  logic                   frame_end;
  logic [ROW_W-1:0]       rd_row;
  logic [ROW_W-1:0]       sh_row;
  logic [NUM_STROBES-1:0] strobe_q;

  assign start       = en_i && !started;
  assign run         = en_i && started;
  assign gap_clamped = (32'(gap_i) >= ROWS) ? ROW_W'(ROWS - 1) : gap_i;
  assign frame_end   = slot_end && (rd_row == ROW_W'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      gap_q   <= '0;
    end else begin
      if (start) started <= 1'b1;
      if (start || frame_end) gap_q <= gap_clamped;
    end
  end

  drs_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cyc      (cyc),
    .slot_end (slot_end)
  );

  drs_row_ptr #(.ROWS(ROWS)) u_rd_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (slot_end),
    .load     (start),
    .load_val ('0),
    .row      (rd_row)
  );

  drs_row_ptr #(.ROWS(ROWS)) u_sh_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (slot_end),
    .load     (start || frame_end),
    .load_val (gap_clamped),
    .row      (sh_row)
  );

  drs_phase_gen #(.ROWS(ROWS), .SLOT_CYCLES(SLOT_CYCLES)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sh_enable (gap_q != '0),
    .cyc       (cyc),
    .rd_row    (rd_row),
    .sh_row    (sh_row),
    .strobe_q  (strobe_q),
    .sel_q     (rd_sel_o),
    .rd_row_q  (rd_row_o),
    .sh_row_q  (sh_row_o)
  );

  assign smp_s_o  = strobe_q[int'(K_SIG_S)];
  assign rd_rst_o = strobe_q[int'(K_RD_RST)];
  assign smp_r_o  = strobe_q[int'(K_SIG_R)];
  assign rd_tx_o  = strobe_q[int'(K_RD_TX)];
  assign smp_l_o  = strobe_q[int'(K_SIG_L)];
  assign sh_rst_o = strobe_q[int'(K_SH_RST)];
  assign sh_tx_o  = strobe_q[int'(K_SH_TX)];
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int unsigned ROWS = 240,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [ROW_W-1:0] gap_q,
  input logic [ROW_W-1:0] rd_row_o,
  input logic [ROW_W-1:0] sh_row_o,
  input logic             rd_sel_o,
  input logic             rd_rst_o,
  input logic             rd_tx_o,
  input logic             sh_rst_o,
  input logic             sh_tx_o,
  input logic             smp_s_o,
  input logic             smp_r_o,
  input logic             smp_l_o
);
  logic [6:0] strobes;
  assign strobes = {sh_tx_o, sh_rst_o, smp_l_o, rd_tx_o, smp_r_o, rd_rst_o, smp_s_o};

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  // R2
  sel_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_s_o || rd_rst_o || smp_r_o || rd_tx_o || smp_l_o) |-> rd_sel_o);

  // R8
  zero_gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == '0) |-> !(sh_rst_o || sh_tx_o));

  // R9
  shutter_other_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rst_o || sh_tx_o) |-> (sh_row_o != rd_row_o));

  // R5
  shutter_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rst_o || sh_tx_o) |->
      ((32'(rd_row_o) + 32'(gap_q)) % ROWS == 32'(sh_row_o)));

  // R4
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_row_o) < ROWS) && (32'(sh_row_o) < ROWS));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_row_o != $past(rd_row_o)) |->
      ((32'(rd_row_o) == 32'($past(rd_row_o)) + 1) ||
       ((32'($past(rd_row_o)) == ROWS - 1) && (rd_row_o == '0))));

  // R10
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> ((strobes == '0) && !rd_sel_o));
endmodule

bind dual_roll_ctrl drs_checker #(.ROWS(ROWS)) u_drs_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .gap_q    (gap_q),
  .rd_row_o (rd_row_o),
  .sh_row_o (sh_row_o),
  .rd_sel_o (rd_sel_o),
  .rd_rst_o (rd_rst_o),
  .rd_tx_o  (rd_tx_o),
  .sh_rst_o (sh_rst_o),
  .sh_tx_o  (sh_tx_o),
  .smp_s_o  (smp_s_o),
  .smp_r_o  (smp_r_o),
  .smp_l_o  (smp_l_o)
);

// File: tb/test_dual_roll_ctrl.sv
`timescale 1ns/1ps
module test_dual_roll_ctrl;
  import drs_pkg::*;

  localparam int ROWS = 240;
  localparam int SLOT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] gap = 8'd0;
  logic [7:0] rd_row_o, sh_row_o;
  logic       rd_sel_o, rd_rst_o, rd_tx_o, sh_rst_o, sh_tx_o;
  logic       smp_s_o, smp_r_o, smp_l_o;

  always #2.5 clk = ~clk;

  dual_roll_ctrl #(.ROWS(ROWS), .SLOT_CYCLES(SLOT)) i_dual_roll_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .gap_i(gap),
    .rd_row_o(rd_row_o), .sh_row_o(sh_row_o), .rd_sel_o(rd_sel_o),
    .rd_rst_o(rd_rst_o), .rd_tx_o(rd_tx_o), .sh_rst_o(sh_rst_o),
    .sh_tx_o(sh_tx_o), .smp_s_o(smp_s_o), .smp_r_o(smp_r_o), .smp_l_o(smp_l_o)
  );

  typedef struct {
    strobe_e kind;
    int      row;
    int      delta;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0;
  int    n_err = 0;
  int    last_ph = -1;
  int    since = 0;
  bit    skip_next = 1'b0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input strobe_e k, input int row);
    item_t it;
    int ph;
    int d;
    ph = int'(PHASE[int'(k)]);
    if (last_ph < 0) d = -1;
    else begin
      d = (ph - last_ph + SLOT) % SLOT;
      if (d == 0) d = SLOT;
    end
    it.kind = k; it.row = row; it.delta = d;
    exp_q.push_back(it);
    last_ph = ph;
  endtask

  // one frame of expected strobes; g is the gap already clamped (R7)
  task automatic push_frame(input int g);
    for (int r = 0; r < ROWS; r++) begin
      push(K_SIG_S, r);
      push(K_RD_RST, r);
      push(K_SIG_R, r);
      push(K_RD_TX, r);
      push(K_SIG_L, r);
      if (g != 0) begin           // R8: gap 0 drops the shutter strobes
        push(K_SH_RST, (r + g) % ROWS);
        push(K_SH_TX, (r + g) % ROWS);
      end
    end
  endtask

  task automatic wait_row(input int r);
    do @(negedge clk); while (int'(rd_row_o) != r);
  endtask

  // monitor: pops the scoreboard as strobes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [6:0] s;
      s = {sh_tx_o, sh_rst_o, smp_l_o, rd_tx_o, smp_r_o, rd_rst_o, smp_s_o};
      since++;
      if ($countones(s) > 1) begin
        check(1'b0, "R9", "strobes in one cycle", $countones(s), 1);
      end else if (s != '0) begin
        int k;
        int row;
        item_t it;
        k = 0;
        for (int i = 0; i < 7; i++) if (s[i]) k = i;
        row = (k >= int'(SHUTTER_FIRST)) ? int'(sh_row_o) : int'(rd_row_o);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected strobe kind", k, -1);
        end else begin
          it = exp_q.pop_front();
          if (int'(it.kind) >= int'(SHUTTER_FIRST)) begin
            check(k == int'(it.kind), "R3", "shutter strobe kind", k, int'(it.kind));
            check(row == it.row, "R5/R6/R7", "shutter row", row, it.row);
            check(sh_row_o != rd_row_o, "R9", "shutter on readout row",
                  int'(sh_row_o), -1);
          end else begin
            check(k == int'(it.kind), "R2", "readout strobe kind", k, int'(it.kind));
            check(row == it.row, "R4", "readout row", row, it.row);
            check(rd_sel_o, "R2", "select during readout strobe", int'(rd_sel_o), 1);
          end
          if (it.delta >= 0 && !skip_next)
            check(since == it.delta, "R2", "cycles between strobes", since, it.delta);
          skip_next = 1'b0;
        end
        since = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    // R1: everything quiet under reset
    check(rd_row_o == 0 && sh_row_o == 0, "R1", "row addresses", int'(rd_row_o), 0);
    check({rd_sel_o, rd_rst_o, rd_tx_o, sh_rst_o, sh_tx_o, smp_s_o, smp_r_o, smp_l_o} == '0,
          "R1", "strobes and select", int'(rd_sel_o), 0);
    rst_n = 1'b1;

    push_frame(5);     // R6: gap latched at start
    push_frame(0);     // R8
    push_frame(239);   // R7: 250 clamps
    push_frame(1);
    push_frame(1);

    @(negedge clk);
    gap = 8'd5;
    en  = 1'b1;
    wait_row(100);
    gap = 8'd0;        // R6: takes effect at the next frame only
    wait_row(0);
    wait_row(100);
    gap = 8'd250;
    wait_row(0);
    wait_row(100);
    gap = 8'd1;
    wait_row(0);
    wait_row(50);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    begin
      logic [7:0] hold_rd, hold_sh;
      hold_rd = rd_row_o;
      hold_sh = sh_row_o;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        // R10: frozen while disabled
        check({rd_sel_o, rd_rst_o, rd_tx_o, sh_rst_o, sh_tx_o, smp_s_o, smp_r_o, smp_l_o} == '0,
              "R10", "activity while disabled", int'(rd_sel_o), 0);
        check(rd_row_o == hold_rd && sh_row_o == hold_sh, "R10", "row held",
              int'(rd_row_o), int'(hold_rd));
      end
    end
    skip_next = 1'b1;
    en = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule